// File: doc/BRIEF.md
# Two-Wire Slave to Parallel Register Bridge

This block is a slave on a two-wire serial bus (SCL clock, SDA open-drain data). It turns register accesses arriving on that bus into commands on an on-chip parallel register bus. Both bus lines are oversampled by the system clock. They pass through a synchronizer and a glitch filter before start, stop and clock-edge events are derived from them. The block drives SDA only low, through a drive-low enable, and never drives it high.

A write access has four bytes:
- the device address byte with the direction bit cleared;
- a one-byte register index;
- two data bytes, low byte first.

Once the last data byte has been acknowledged, the bridge issues a single one-cycle write strobe that carries the index and the assembled 16-bit value. If the access is cut short by a stop or a repeated start, no write is issued.

A read access is addressed with the direction bit set. It returns the 16-bit register value for the index most recently received, low byte first. The slave releases SDA as soon as the master fails to acknowledge a byte.

Top module: `i2c_regbridge`

## Requirements
- R1: After reset, sda_drive_low_o and wr_strobe_o are 0.
- R2: The bridge acknowledges an address byte whose upper seven bits equal 0x4A, by driving SDA low during the ninth clock. Bit 0 of that byte selects the direction: 0 (byte 0x94) means write and 1 (byte 0x95) means read.
- R3: For any other address, the bridge acknowledges nothing and drives nothing, and issues no write, until the next start condition.
- R4: In a write, the bridge acknowledges the register index byte and both data bytes. Every byte is shifted most significant bit first.
- R5: A write raises wr_strobe_o for exactly one cycle, after the high data byte's acknowledge clock has ended. In that cycle wr_index_o holds the index and wr_value_o holds {high byte, low byte}.
- R6: A write cut short by a stop or a repeated start, before the high data byte has been acknowledged, issues no strobe.
- R7: Bytes sent after the high data byte are not acknowledged, and they cause no further strobe.
- R8: In a read, the bridge shifts out rd_value_i[7:0] and then rd_value_i[15:8], most significant bit first. rd_index_o holds the index most recently received.
- R9: When the master does not acknowledge a read byte, the bridge releases SDA for the rest of the transaction.
- R10: The bridge changes its SDA drive only while SCL is low. It drives SDA only in its own acknowledge bits and read data bits.
- R11: Pulses on SCL or SDA shorter than FILT_LEN system clocks have no effect on the bus state.
- R12: With a 50 MHz system clock, transfers work at both 100 kbit/s (500 clocks per bit) and 400 kbit/s (125 clocks per bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_drive_low_o | output | 1 | Pulls SDA low when 1; releases the line when 0 |
| wr_strobe_o | output | 1 | One-cycle parallel write command |
| wr_index_o | output | 8 | Register index of the write command |
| wr_value_o | output | 16 | Data of the write command |
| rd_index_o | output | 8 | Index of the register whose value is returned on reads |
| rd_value_i | input | 16 | Value of the register selected by rd_index_o |

## Verification
The bench tries several kinds of access, and each one separates a different fault:
- Complete writes at the slow and the fast bit rate show whether byte order, bit order and strobe placement are right.
- Writes to foreign addresses, and writes cut off by a stop or by a repeated start, show whether the bridge issues a strobe it must not.
- A write with a trailing extra byte, and reads with and without a master acknowledge, show whether acknowledge handling and SDA release work.
- One write carries short pulses on both lines, which shows whether the filter is in place.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } link_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

endpackage

// File: rtl/i2cb_deglitch.sv
module i2cb_deglitch #(
    parameter int LINES    = 2,
    parameter int FILT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] clean_o
);

    typedef struct packed {
        logic [LINES-1:0][1:0]          sync;
        logic [LINES-1:0][FILT_LEN-1:0] hist;
        logic [LINES-1:0]               level;
    } filt_state_t;

    filt_state_t d, q;

    always_comb begin
        d = q;
        for (int i = 0; i < LINES; i++) begin
            d.sync[i] = {q.sync[i][0], raw_i[i]};
            d.hist[i] = {q.hist[i][FILT_LEN-2:0], q.sync[i][1]};
            if (&q.hist[i]) begin
                d.level[i] = 1'b1;
            end else if (~|q.hist[i]) begin
                d.level[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign clean_o = q.level;

endmodule

// File: rtl/i2cb_bus_events.sv
module i2cb_bus_events
    import i2cb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t d, q;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        evt_o.rise  = scl_i & ~q.scl;
        evt_o.fall  = ~scl_i & q.scl;
        evt_o.start = scl_i & q.scl & q.sda & ~sda_i;
        evt_o.stop  = scl_i & q.scl & ~q.sda & sda_i;
    end

endmodule

// File: rtl/i2cb_link.sv
module i2cb_link
    import i2cb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4A,
    parameter int         DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt_i,
    input  logic              sda_i,
    input  logic [DATA_W-1:0] rd_value_i,
    output logic              drive_low_o,
    output logic              wr_strobe_o,
    output logic [7:0]        wr_index_o,
    output logic [DATA_W-1:0] wr_value_o,
    output logic [7:0]        rd_index_o,
    output logic              ignoring_o
);

    localparam int NBYTES = DATA_W / 8;
    localparam int POS_W  = $clog2(NBYTES + 3);
    localparam logic [POS_W-1:0] POS_INDEX = POS_W'(1);
    localparam logic [POS_W-1:0] POS_FIRST = POS_W'(2);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(NBYTES + 1);
    localparam logic [POS_W-1:0] TB_LAST   = POS_W'(NBYTES - 1);

    typedef struct packed {
        link_state_e       st;
        logic [7:0]        shreg;
        logic [3:0]        bitcnt;
        logic [POS_W-1:0]  pos;
        logic              is_read;
        logic [7:0]        index;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rhold;
        logic [POS_W-1:0]  tbyte;
        logic              mack;
        logic              drive;
        logic              strobe;
    } link_t;

    link_t d, q;
    logic [DATA_W-1:0] rshift;
    logic [7:0]        next_tx;

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        rshift   = q.rhold >> (8 * (int'(q.tbyte) + 1));
        next_tx  = rshift[7:0];

        if (evt_i.start) begin
            d.st     = ST_RX;
            d.bitcnt = '0;
            d.pos    = '0;
            d.drive  = 1'b0;
        end else if (evt_i.stop) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (evt_i.rise) begin
                        d.shreg  = {q.shreg[6:0], sda_i};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (evt_i.fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        d.st     = ST_RX_ACK;
                        d.drive  = 1'b1;
                        if (q.pos == '0) begin
                            d.is_read = q.shreg[0];
                            if (q.shreg[7:1] != DEV_ADDR) begin
                                d.st    = ST_IGNORE;
                                d.drive = 1'b0;
                            end
                        end else if (q.pos == POS_INDEX) begin
                            d.index = q.shreg;
                        end else if (q.pos >= POS_FIRST && q.pos <= POS_LAST) begin
                            d.wdata[8*(int'(q.pos)-2) +: 8] = q.shreg;
                        end else begin
                            d.st    = ST_IGNORE;
                            d.drive = 1'b0;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (evt_i.fall) begin
                        d.drive = 1'b0;
                        d.pos   = q.pos + 1'b1;
                        d.st    = ST_RX;
                        if (q.pos == POS_LAST) begin
                            d.strobe = 1'b1;
                        end
                        if (q.pos == '0 && q.is_read) begin
                            d.st     = ST_TX;
                            d.rhold  = rd_value_i;
                            d.shreg  = rd_value_i[7:0];
                            d.drive  = ~rd_value_i[7];
                            d.tbyte  = '0;
                            d.bitcnt = '0;
                        end
                    end
                end
                ST_TX: begin
                    if (evt_i.rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (evt_i.fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.drive  = 1'b0;
                            d.st     = ST_TX_ACK;
                            d.bitcnt = '0;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.drive = ~q.shreg[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (evt_i.rise) begin
                        d.mack = ~sda_i;
                    end else if (evt_i.fall) begin
                        if (q.mack && q.tbyte != TB_LAST) begin
                            d.tbyte = q.tbyte + 1'b1;
                            d.shreg = next_tx;
                            d.drive = ~next_tx[7];
                            d.st    = ST_TX;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign drive_low_o = q.drive;
    assign wr_strobe_o = q.strobe;
    assign wr_index_o  = q.index;
    assign wr_value_o  = q.wdata;
    assign rd_index_o  = q.index;
    assign ignoring_o  = (q.st == ST_IGNORE);

endmodule

// File: rtl/i2c_regbridge.sv
module i2c_regbridge
    import i2cb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4A,
    parameter int         DATA_W   = 16,
    parameter int         FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low_o,
    output logic              wr_strobe_o,
    output logic [7:0]        wr_index_o,
    output logic [DATA_W-1:0] wr_value_o,
    output logic [7:0]        rd_index_o,
    input  logic [DATA_W-1:0] rd_value_i
);

    logic [1:0] clean;
    logic       scl_f;
    logic       sda_f;
    bus_evt_t   evt;
    logic       scl_fall_w;
    logic       stop_w;
    logic       ignoring;

    i2cb_deglitch #(
        .LINES   (2),
        .FILT_LEN(FILT_LEN)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .clean_o(clean)
    );

    assign scl_f = clean[0];
    assign sda_f = clean[1];

    i2cb_bus_events u_evt (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_i(scl_f),
        .sda_i(sda_f),
        .evt_o(evt)
    );

    assign scl_fall_w = evt.fall;
    assign stop_w     = evt.stop;

    i2cb_link #(
        .DEV_ADDR(DEV_ADDR),
        .DATA_W  (DATA_W)
    ) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .sda_i      (sda_f),
        .rd_value_i (rd_value_i),
        .drive_low_o(sda_drive_low_o),
        .wr_strobe_o(wr_strobe_o),
        .wr_index_o (wr_index_o),
        .wr_value_o (wr_value_o),
        .rd_index_o (rd_index_o),
        .ignoring_o (ignoring)
    );

endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_filt,
    input logic scl_fall,
    input logic stop_evt,
    input logic drive,
    input logic strobe,
    input logic ignoring
);

    // R5: the write command lasts one cycle
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R5: the write command follows the end of an acknowledge clock
    p_strobe_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(scl_fall));

    // R6: a stop never produces a write command
    p_no_strobe_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !strobe);

    // R3: an ignored transaction leaves SDA released
    p_silent_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ignoring |-> !drive);

    // R10: the SDA drive is steady while SCL stays high
    p_hold_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_filt && $past(scl_filt)) |-> $stable(drive));

endmodule

bind i2c_regbridge i2cb_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_filt(scl_f),
    .scl_fall(scl_fall_w),
    .stop_evt(stop_w),
    .drive   (sda_drive_low_o),
    .strobe  (wr_strobe_o),
    .ignoring(ignoring)
);

// File: tb/i2c_regbridge_tb_top.sv
module i2c_regbridge_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int Q_SLOW     = 125;
    localparam int Q_FAST     = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        drive;
    logic        strobe;
    logic [7:0]  wr_index;
    logic [15:0] wr_value;
    logic [7:0]  rd_index;
    logic [15:0] rd_value;
    logic        sda_bus;

    int   errors = 0;
    int   checks = 0;
    int   q_cyc = Q_FAST;
    int   stray = 0;
    int   strobe_count = 0;
    logic slave_ok = 1'b0;
    logic prev_strobe = 1'b0;
    logic scl_glitch_arm = 1'b0;
    logic sda_glitch_arm = 1'b0;
    logic done = 1'b0;
    logic [23:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus  = sda_m & ~drive;
    assign rd_value = {rd_index ^ 8'h5A, ~rd_index};

    i2c_regbridge dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl),
        .sda_i          (sda_bus),
        .sda_drive_low_o(drive),
        .wr_strobe_o    (strobe),
        .wr_index_o     (wr_index),
        .wr_value_o     (wr_value),
        .rd_index_o     (rd_index),
        .rd_value_i     (rd_value)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl && drive && !slave_ok) stray++;
            if (strobe) begin
                strobe_count++;
                chk("R5", "strobe single cycle", {31'd0, prev_strobe}, 32'd0);
                if (exp_q.size() == 0) begin
                    chk("R6", "unexpected strobe", {8'd0, wr_index, wr_value}, 32'd0);
                end else begin
                    chk("R5", "strobe index/value", {8'd0, wr_index, wr_value},
                        {8'd0, exp_q.pop_front()});
                end
            end
            prev_strobe = strobe;
        end
    end

    task automatic wq();
        repeat (q_cyc) @(negedge clk);
    endtask

    task automatic xbit(input logic v, input logic let_slave, output logic r);
        wq();
        sda_m = v;
        slave_ok = let_slave;
        if (scl_glitch_arm) begin
            scl = 1'b1;
            repeat (2) @(negedge clk);
            scl = 1'b0;
            scl_glitch_arm = 1'b0;
        end
        wq();
        scl = 1'b1;
        wq();
        r = sda_bus;
        if (sda_glitch_arm && v) begin
            sda_m = 1'b0;
            repeat (2) @(negedge clk);
            sda_m = 1'b1;
            sda_glitch_arm = 1'b0;
        end
        wq();
        scl = 1'b0;
    endtask

    task automatic bus_start();
        wq();
        sda_m = 1'b1;
        slave_ok = 1'b0;
        wq();
        scl = 1'b1;
        wq();
        sda_m = 1'b0;
        wq();
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wq();
        sda_m = 1'b0;
        slave_ok = 1'b0;
        wq();
        scl = 1'b1;
        wq();
        sda_m = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) xbit(b[i], 1'b0, r);
        xbit(1'b1, 1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic slave_active, input logic master_ack,
                             output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            xbit(1'b1, slave_active, r);
            b[i] = r;
        end
        xbit(~master_ack, 1'b0, r);
    endtask

    initial begin
        logic       ack;
        logic [7:0] rb;
        int         base;

        repeat (10) @(negedge clk);
        chk("R1", "drive after reset", {31'd0, drive}, 32'd0);
        chk("R1", "strobe after reset", {31'd0, strobe}, 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // slow full write
        q_cyc = Q_SLOW;
        bus_start();
        send_byte(8'h94, ack); chk("R2", "write address ack", {31'd0, ack}, 32'd1);
        send_byte(8'h09, ack); chk("R4", "index ack", {31'd0, ack}, 32'd1);
        send_byte(8'h84, ack); chk("R4", "low byte ack", {31'd0, ack}, 32'd1);
        exp_q.push_back({8'h09, 16'h0284});
        send_byte(8'h02, ack); chk("R12", "high byte ack slow", {31'd0, ack}, 32'd1);
        bus_stop();
        chk("R12", "slow write delivered", exp_q.size(), 32'd0);

        // fast full write
        q_cyc = Q_FAST;
        bus_start();
        send_byte(8'h94, ack);
        send_byte(8'hC3, ack);
        send_byte(8'hA5, ack);
        exp_q.push_back({8'hC3, 16'h5AA5});
        send_byte(8'h5A, ack); chk("R12", "high byte ack fast", {31'd0, ack}, 32'd1);
        bus_stop();
        chk("R5", "fast write delivered", exp_q.size(), 32'd0);

        // foreign addresses
        base = strobe_count;
        bus_start();
        send_byte(8'h90, ack); chk("R3", "foreign address nack", {31'd0, ack}, 32'd0);
        send_byte(8'h11, ack); chk("R3", "ignored byte nack", {31'd0, ack}, 32'd0);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack); chk("R3", "ignored data nack", {31'd0, ack}, 32'd0);
        bus_stop();
        bus_start();
        send_byte(8'h96, ack); chk("R3", "neighbour address nack", {31'd0, ack}, 32'd0);
        bus_stop();
        chk("R3", "no strobe for foreign address", strobe_count - base, 32'd0);

        // cut short by stop
        base = strobe_count;
        bus_start();
        send_byte(8'h94, ack);
        send_byte(8'h40, ack);
        send_byte(8'h11, ack);
        bus_stop();
        chk("R6", "no strobe after stop", strobe_count - base, 32'd0);

        // cut short by repeated start, then a full write
        base = strobe_count;
        bus_start();
        send_byte(8'h94, ack);
        send_byte(8'h41, ack);
        send_byte(8'h12, ack);
        bus_start();
        send_byte(8'h94, ack); chk("R2", "address after repeated start", {31'd0, ack}, 32'd1);
        send_byte(8'h42, ack);
        send_byte(8'h34, ack);
        exp_q.push_back({8'h42, 16'h5634});
        send_byte(8'h56, ack);
        bus_stop();
        chk("R6", "one strobe across repeated start", strobe_count - base, 32'd1);

        // read after index-only write
        base = strobe_count;
        bus_start();
        send_byte(8'h94, ack);
        send_byte(8'h77, ack);
        bus_start();
        send_byte(8'h95, ack); chk("R2", "read address ack", {31'd0, ack}, 32'd1);
        chk("R8", "read index", {24'd0, rd_index}, 32'h77);
        recv_byte(1'b1, 1'b1, rb); chk("R8", "read low byte", {24'd0, rb}, 32'h88);
        recv_byte(1'b1, 1'b0, rb); chk("R8", "read high byte", {24'd0, rb}, 32'h2D);
        bus_stop();
        chk("R8", "no strobe for index-only write", strobe_count - base, 32'd0);

        // read with early master nack
        bus_start();
        send_byte(8'h95, ack);
        recv_byte(1'b1, 1'b0, rb); chk("R8", "read low byte again", {24'd0, rb}, 32'h88);
        recv_byte(1'b0, 1'b0, rb); chk("R9", "released after nack", {24'd0, rb}, 32'hFF);
        bus_stop();

        // trailing extra byte
        base = strobe_count;
        bus_start();
        send_byte(8'h94, ack);
        send_byte(8'h10, ack);
        send_byte(8'hEF, ack);
        exp_q.push_back({8'h10, 16'hBEEF});
        send_byte(8'hBE, ack);
        send_byte(8'h99, ack); chk("R7", "extra byte nack", {31'd0, ack}, 32'd0);
        bus_stop();
        chk("R7", "single strobe with extra byte", strobe_count - base, 32'd1);

        // short pulses on both lines
        bus_start();
        send_byte(8'h94, ack);
        scl_glitch_arm = 1'b1;
        send_byte(8'h2B, ack); chk("R11", "index ack with scl pulse", {31'd0, ack}, 32'd1);
        sda_glitch_arm = 1'b1;
        send_byte(8'hF0, ack); chk("R11", "low ack with sda pulse", {31'd0, ack}, 32'd1);
        exp_q.push_back({8'h2B, 16'h4DF0});
        send_byte(8'h4D, ack);
        bus_stop();
        chk("R11", "filtered write delivered", exp_q.size(), 32'd0);

        chk("R10", "drive outside slave bits", stray, 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule